// File: doc/BRIEF.md
# Dual-Buffer Sequential Address Sequencer

This block generates the address for a sequential-access word memory of 8K words by 16 bits. The address space is split into two buffers. Each buffer has a programmable first address and last address. On every rising clock edge with count enable high, a 13-bit pointer steps forward. When the pointer sits on a buffer's last address, that buffer's sticky status flag is set. The buffer's own 2-bit policy then decides what happens next: jump to the other buffer, halt, keep counting, or keep counting with the active-low end-of-buffer output held back.

Software sets the policies, the four buffer addresses and the flag clears through a small 16-bit register port. Writes are clocked and reads are combinational. A pointer load strobe and two buffer-start strobes move the pointer directly. A write-inhibit output tells the memory side that the pointer has halted. The memory array is not part of this block.

Top module: `seqbuf_addr_seq`

## Requirements
- R1: After reset: pointer is 0; both policies are "continue" (the policy register reads 0x000A); both flags are clear; both end outputs are high; write-inhibit is low.
- R2: Register select codes: 0 = policy, 1 = flags, 2 = buffer-1 first address, 3 = buffer-1 last address, 4 = buffer-2 first address, 5 = buffer-2 last address. Addresses sit in bits 12:0. In the policy register, bits 1:0 hold the buffer-1 policy and bits 3:2 hold the buffer-2 policy, coded 00 jump, 01 halt, 10 continue, 11 masked. It reads back with zeros above bit 3.
- R3: With no end match, no halt and no strobe, an edge with count enable high adds 1 to the pointer, wrapping from 0x1FFF to 0. With count enable low, the pointer holds.
- R4: On every edge where the pointer equals a buffer's last address, that buffer's flag is set. Under the jump, halt and continue policies, the end output is low while the flag is set. A clear arriving in the same cycle as a match loses.
- R5: Jump policy: an enabled edge while the pointer is on buffer 1's last address loads buffer 2's first address, and the reverse for buffer 2.
- R6: If both last addresses are equal and a jump applies, the pointer goes to buffer 1's first address, and both flags are set.
- R7: Halt policy: on the edge after the pointer reaches the last address, the block halts. It moves to last+1 first if count enable is high on that edge, and stays on last otherwise. While halted, write-inhibit is high and count enable does not move the pointer.
- R8: Writing the policy register with bit 4 = 0 while halted arms a release. If count enable is high on the following edge, the pointer steps by 1 and write-inhibit drops. Otherwise the release is dropped and the block stays halted.
- R9: Strobe priority is load > buffer-1 start > buffer-2 start > counting. Any strobe clears the halt.
- R10: Masked policy: the end output stays high, the flag bit still reads 1, and the pointer keeps counting.
- R11: Flag register write: a 0 in bit 0 (bit 1) clears buffer-1 (buffer-2) flag, and a 1 leaves it as it was. Reads show flag 1 in bit 0 and flag 2 in bit 1.
- R12: Reads of select codes 6 and 7 return 0xFFFF.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_en | input | 1 | Count enable, active high |
| ptr_ld | input | 1 | Load pointer from ld_addr |
| ld_addr | input | 13 | Value for a pointer load |
| start1_go | input | 1 | Move pointer to buffer-1 first address |
| start2_go | input | 1 | Move pointer to buffer-2 first address |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ptr | output | 13 | Current pointer |
| eob1_n | output | 1 | Buffer-1 end output, active low |
| eob2_n | output | 1 | Buffer-2 end output, active low |
| wr_inhibit | output | 1 | High while the pointer is halted |

## Verification
The bench sends the pointer across both last addresses under each policy. A design that raised the flag a cycle early, or let a flag clear win against a live match, would show the wrong end output at the sampled edge. With equal last addresses it checks that the jump lands on buffer 1 and that both flags read back; a design that favoured buffer 2 would land at 0x1200. It halts the pointer both with and without count enable on the decision edge, and releases it both with and without an enabled follow-up edge. A release that was sticky, or a halt that moved one address too far, shows up as a wrong pointer value. It also checks strobe priority, masked output suppression and the all-ones reserved reads.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;
  typedef enum logic [1:0] {
    EOB_CHAIN  = 2'b00,
    EOB_STOP   = 2'b01,
    EOB_LINEAR = 2'b10,
    EOB_MASK   = 2'b11
  } eob_mode_e;

  localparam int unsigned SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_FLOW = 3'd0;
  localparam logic [SEL_W-1:0] SEL_FLAG = 3'd1;
  localparam logic [SEL_W-1:0] SEL_S1   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_E1   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_S2   = 3'd4;
  localparam logic [SEL_W-1:0] SEL_E2   = 3'd5;

  // bit position of the release command in the policy register
  localparam int unsigned REL_BIT = 4;

  // sticky flag: a live match wins over a clear request
  function automatic logic flag_next(input logic hit, input logic cur, input logic clr);
    return hit | (cur & ~clr);
  endfunction

  // end output, active low; masked policy never drives it
  function automatic logic eob_level(input logic flag, input eob_mode_e mode);
    return ~(flag && (mode != EOB_MASK));
  endfunction
endpackage

// File: rtl/seqbuf_regs.sv
module seqbuf_regs
  import seqbuf_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16,
  parameter logic [AW-1:0] S1_RST = 13'h0000,
  parameter logic [AW-1:0] E1_RST = 13'h0FFF,
  parameter logic [AW-1:0] S2_RST = 13'h1000,
  parameter logic [AW-1:0] E2_RST = 13'h1FFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             flag1,
  input  logic             flag2,
  output eob_mode_e        mode1,
  output eob_mode_e        mode2,
  output logic [AW-1:0]    b1_start,
  output logic [AW-1:0]    b1_end,
  output logic [AW-1:0]    b2_start,
  output logic [AW-1:0]    b2_end,
  output logic             rel_req,
  output logic             flag_wr,
  output logic [DW-1:0]    reg_rdata
);
  localparam int unsigned PAD = DW - AW;

  logic flow_wr;
  logic unused_hi;
  assign unused_hi = ^reg_wdata[DW-1:REL_BIT+1];

  assign flow_wr = reg_we && (reg_sel == SEL_FLOW);
  assign flag_wr = reg_we && (reg_sel == SEL_FLAG);
  assign rel_req = flow_wr && !reg_wdata[REL_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode1    <= EOB_LINEAR;
      mode2    <= EOB_LINEAR;
      b1_start <= S1_RST;
      b1_end   <= E1_RST;
      b2_start <= S2_RST;
      b2_end   <= E2_RST;
    end else if (reg_we) begin
      case (reg_sel)
        SEL_FLOW: begin
          mode1 <= eob_mode_e'(reg_wdata[1:0]);
          mode2 <= eob_mode_e'(reg_wdata[3:2]);
        end
        SEL_S1:  b1_start <= reg_wdata[AW-1:0];
        SEL_E1:  b1_end   <= reg_wdata[AW-1:0];
        SEL_S2:  b2_start <= reg_wdata[AW-1:0];
        SEL_E2:  b2_end   <= reg_wdata[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_FLOW: reg_rdata = {{(DW-4){1'b0}}, mode2, mode1};
      SEL_FLAG: reg_rdata = {{(DW-2){1'b0}}, flag2, flag1};
      SEL_S1:   reg_rdata = {{PAD{1'b0}}, b1_start};
      SEL_E1:   reg_rdata = {{PAD{1'b0}}, b1_end};
      SEL_S2:   reg_rdata = {{PAD{1'b0}}, b2_start};
      SEL_E2:   reg_rdata = {{PAD{1'b0}}, b2_end};
      default:  reg_rdata = '1;
    endcase
  end
endmodule

// File: rtl/seqbuf_flags.sv
module seqbuf_flags
  import seqbuf_pkg::*;
#(
  parameter int unsigned NBUF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NBUF-1:0] hit,
  input  logic            flag_wr,
  input  logic [NBUF-1:0] wr_bits,
  input  eob_mode_e       mode [NBUF],
  output logic [NBUF-1:0] flag,
  output logic [NBUF-1:0] eob_n
);
  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic clr;
    assign clr = flag_wr && !wr_bits[b];

    always_ff @(posedge clk) begin
      if (!rst_n) flag[b] <= 1'b0;
      else        flag[b] <= flag_next(hit[b], flag[b], clr);
    end

    assign eob_n[b] = eob_level(flag[b], mode[b]);
  end
endmodule

// File: rtl/seqbuf_ptr.sv
module seqbuf_ptr
  import seqbuf_pkg::*;
#(
  parameter int unsigned AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ld_addr,
  input  logic          start1_go,
  input  logic          start2_go,
  input  logic          rel_req,
  input  eob_mode_e     mode1,
  input  eob_mode_e     mode2,
  input  logic [AW-1:0] b1_start,
  input  logic [AW-1:0] b1_end,
  input  logic [AW-1:0] b2_start,
  input  logic [AW-1:0] b2_end,
  output logic [AW-1:0] ptr,
  output logic          halted,
  output logic          rel_armed,
  output logic          hit1,
  output logic          hit2
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return p + {{(AW-1){1'b0}}, 1'b1};
  endfunction

  logic          chain1, chain2, chain_any, stop_hit, jump_any;
  logic [AW-1:0] chain_tgt, jump_tgt;

  assign hit1      = (ptr == b1_end);
  assign hit2      = (ptr == b2_end);
  assign chain1    = hit1 && (mode1 == EOB_CHAIN);
  assign chain2    = hit2 && (mode2 == EOB_CHAIN);
  assign chain_any = chain1 || chain2;
  // a buffer-2 jump goes to buffer 1; this also covers equal last addresses
  assign chain_tgt = chain2 ? b1_start : b2_start;
  assign stop_hit  = !chain_any &&
                     ((hit1 && (mode1 == EOB_STOP)) || (hit2 && (mode2 == EOB_STOP)));
  assign jump_any  = ptr_ld || start1_go || start2_go;
  assign jump_tgt  = ptr_ld ? ld_addr : (start1_go ? b1_start : b2_start);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      halted    <= 1'b0;
      rel_armed <= 1'b0;
    end else if (jump_any) begin
      ptr       <= jump_tgt;
      halted    <= 1'b0;
      rel_armed <= 1'b0;
    end else if (halted) begin
      if (rel_armed) begin
        rel_armed <= 1'b0;
        if (cnt_en) begin
          halted <= 1'b0;
          ptr    <= bump(ptr);
        end
      end else if (rel_req) begin
        rel_armed <= 1'b1;
      end
    end else begin
      rel_armed <= 1'b0;
      if (stop_hit) begin
        halted <= 1'b1;
        if (cnt_en) ptr <= bump(ptr);
      end else if (cnt_en) begin
        ptr <= chain_any ? chain_tgt : bump(ptr);
      end
    end
  end
endmodule

// File: rtl/seqbuf_addr_seq.sv
module seqbuf_addr_seq
  import seqbuf_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             ptr_ld,
  input  logic [AW-1:0]    ld_addr,
  input  logic             start1_go,
  input  logic             start2_go,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic [AW-1:0]    ptr,
  output logic             eob1_n,
  output logic             eob2_n,
  output logic             wr_inhibit
);
  eob_mode_e     mode1, mode2;
  eob_mode_e     mode_arr [2];
  logic [AW-1:0] b1_start, b1_end, b2_start, b2_end;
  logic          rel_req, flag_wr, halted, rel_armed, hit1, hit2;
  logic [1:0]    flag_v, eob_v;
  logic          flag1, flag2;

  assign mode_arr[0] = mode1;
  assign mode_arr[1] = mode2;
  assign flag1       = flag_v[0];
  assign flag2       = flag_v[1];
  assign eob1_n      = eob_v[0];
  assign eob2_n      = eob_v[1];
  assign wr_inhibit  = halted;

  seqbuf_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .flag1(flag1), .flag2(flag2),
    .mode1(mode1), .mode2(mode2), .b1_start(b1_start), .b1_end(b1_end),
    .b2_start(b2_start), .b2_end(b2_end), .rel_req(rel_req),
    .flag_wr(flag_wr), .reg_rdata(reg_rdata)
  );

  seqbuf_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ptr_ld(ptr_ld),
    .ld_addr(ld_addr), .start1_go(start1_go), .start2_go(start2_go),
    .rel_req(rel_req), .mode1(mode1), .mode2(mode2),
    .b1_start(b1_start), .b1_end(b1_end), .b2_start(b2_start),
    .b2_end(b2_end), .ptr(ptr), .halted(halted), .rel_armed(rel_armed),
    .hit1(hit1), .hit2(hit2)
  );

  seqbuf_flags #(.NBUF(2)) u_flags (
    .clk(clk), .rst_n(rst_n), .hit({hit2, hit1}), .flag_wr(flag_wr),
    .wr_bits(reg_wdata[1:0]), .mode(mode_arr), .flag(flag_v), .eob_n(eob_v)
  );
endmodule

// File: rtl/seqbuf_chk.sv
module seqbuf_chk
  import seqbuf_pkg::*;
#(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             ptr_ld,
  input logic [AW-1:0]    ld_addr,
  input logic             start1_go,
  input logic             start2_go,
  input logic             reg_we,
  input logic [SEL_W-1:0] reg_sel,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic [AW-1:0]    ptr,
  input logic             eob1_n,
  input logic             eob2_n,
  input logic             wr_inhibit,
  input eob_mode_e        mode1,
  input eob_mode_e        mode2,
  input logic [AW-1:0]    b1_end,
  input logic [AW-1:0]    b2_start,
  input logic [AW-1:0]    b2_end,
  input logic             flag1,
  input logic             rel_armed
);
  logic no_strobe;
  assign no_strobe = !ptr_ld && !start1_go && !start2_go;

  assert_halt_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inhibit && no_strobe && !rel_armed) |=> ($stable(ptr) && wr_inhibit));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == b1_end) |=> flag1);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (flag1 && !(reg_we && reg_sel == SEL_FLAG && !reg_wdata[0])) |=> flag1);

  assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode1 == EOB_MASK) |-> eob1_n) and ((mode2 == EOB_MASK) |-> eob2_n));

  assert_chain_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_inhibit && cnt_en && no_strobe && ptr == b1_end && mode1 == EOB_CHAIN &&
     !(ptr == b2_end && mode2 == EOB_CHAIN)) |=> (ptr == $past(b2_start)));

  assert_reserved_ones_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel > SEL_E2) |-> (reg_rdata == {DW{1'b1}}));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_inhibit && cnt_en && no_strobe && ptr != b1_end && ptr != b2_end)
    |=> (ptr == $past(ptr) + AW'(1)));

  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_ld |=> (ptr == $past(ld_addr) && !wr_inhibit));
endmodule

bind seqbuf_addr_seq seqbuf_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ptr_ld(ptr_ld),
  .ld_addr(ld_addr), .start1_go(start1_go), .start2_go(start2_go),
  .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n),
  .wr_inhibit(wr_inhibit), .mode1(mode1), .mode2(mode2), .b1_end(b1_end),
  .b2_start(b2_start), .b2_end(b2_end), .flag1(flag1), .rel_armed(rel_armed)
);

// File: tb/test_seqbuf_addr_seq.sv
`timescale 1ns/1ps
module test_seqbuf_addr_seq;
  localparam int AW = 13;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cnt_en = 1'b0, ptr_ld = 1'b0, start1_go = 1'b0, start2_go = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] reg_rdata;
  logic [AW-1:0] ptr;
  logic          eob1_n, eob2_n, wr_inhibit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  seqbuf_addr_seq #(.AW(AW), .DW(DW)) i_seqbuf_addr_seq (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .ptr_ld(ptr_ld),
    .ld_addr(ld_addr), .start1_go(start1_go), .start2_go(start2_go),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ptr(ptr), .eob1_n(eob1_n), .eob2_n(eob2_n),
    .wr_inhibit(wr_inhibit)
  );

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [DW-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [DW-1:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  task automatic load(input logic [AW-1:0] a);
    ptr_ld = 1'b1; ld_addr = a;
    tick();
    ptr_ld = 1'b0;
  endtask

  task automatic steps(input int n);
    cnt_en = 1'b1;
    for (int i = 0; i < n; i++) tick();
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    expect_eq("R1 ptr", ptr, 0);
    expect_eq("R1 eob1_n", eob1_n, 1);
    expect_eq("R1 eob2_n", eob2_n, 1);
    expect_eq("R1 inhibit", wr_inhibit, 0);
    rd(3'd0, d); expect_eq("R1 policy", d, 16'h000A);
    rd(3'd1, d); expect_eq("R1 flags", d, 16'h0000);
  endtask

  task automatic t_linear();
    logic [DW-1:0] d;
    load(13'h0FFD);
    expect_eq("R9 load", ptr, 13'h0FFD);
    steps(2);
    expect_eq("R3 step", ptr, 13'h0FFF);
    expect_eq("R4 not yet", eob1_n, 1);
    tick();
    expect_eq("R3 hold", ptr, 13'h0FFF);
    expect_eq("R4 flag out", eob1_n, 0);
    wr(3'd1, 16'hFFFE);
    expect_eq("R4 match beats clear", eob1_n, 0);
    steps(1);
    expect_eq("R4 continue", ptr, 13'h1000);
    wr(3'd1, 16'hFFFE);
    expect_eq("R11 clear", eob1_n, 1);
    rd(3'd1, d); expect_eq("R11 flags read", d, 0);
    load(13'h1FFF);
    steps(1);
    expect_eq("R3 wrap", ptr, 13'h0000);
    expect_eq("R4 buf2 flag", eob2_n, 0);
    wr(3'd1, 16'hFFFD);
    expect_eq("R11 clear buf2", eob2_n, 1);
  endtask

  task automatic t_chain();
    logic [DW-1:0] d;
    wr(3'd0, 16'h0018);
    rd(3'd0, d); expect_eq("R2 policy read", d, 16'h0008);
    wr(3'd3, 16'h0100);
    wr(3'd4, 16'h1200);
    rd(3'd3, d); expect_eq("R2 end1 read", d, 16'h0100);
    load(13'h00FF);
    steps(2);
    expect_eq("R5 jump to buf2", ptr, 13'h1200);
    expect_eq("R5 eob1", eob1_n, 0);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_equal();
    logic [DW-1:0] d;
    wr(3'd3, 16'h0300);
    wr(3'd5, 16'h0300);
    wr(3'd2, 16'h0040);
    wr(3'd0, 16'h0010);
    load(13'h02FF);
    steps(2);
    expect_eq("R6 jump to buf1", ptr, 13'h0040);
    rd(3'd1, d); expect_eq("R6 both flags", d, 16'h0003);
    expect_eq("R6 eob2", eob2_n, 0);
    wr(3'd1, 16'hFFFE);
    rd(3'd1, d); expect_eq("R11 one kept", d, 16'h0002);
    wr(3'd1, 16'h0000);
  endtask

  task automatic t_stop();
    wr(3'd5, 16'h1FFF);
    wr(3'd3, 16'h0500);
    wr(3'd0, 16'h0019);
    load(13'h04FF);
    steps(2);
    expect_eq("R7 halt at end+1", ptr, 13'h0501);
    expect_eq("R7 inhibit", wr_inhibit, 1);
    steps(1);
    expect_eq("R7 no move", ptr, 13'h0501);
    cnt_en = 1'b1;
    wr(3'd0, 16'h0009);
    expect_eq("R8 armed only", ptr, 13'h0501);
    tick();
    cnt_en = 1'b0;
    expect_eq("R8 release step", ptr, 13'h0502);
    expect_eq("R8 inhibit low", wr_inhibit, 0);
    load(13'h04FF);
    steps(1);
    tick();
    expect_eq("R7 halt at end", ptr, 13'h0500);
    expect_eq("R7 inhibit at end", wr_inhibit, 1);
    wr(3'd0, 16'h0009);
    tick();
    steps(1);
    expect_eq("R8 release lost", ptr, 13'h0500);
    expect_eq("R8 still halted", wr_inhibit, 1);
  endtask

  task automatic t_strobes();
    start1_go = 1'b1; tick(); start1_go = 1'b0;
    expect_eq("R9 start1", ptr, 13'h0040);
    expect_eq("R9 unhalt", wr_inhibit, 0);
    ptr_ld = 1'b1; ld_addr = 13'h0777; start1_go = 1'b1; tick();
    ptr_ld = 1'b0; start1_go = 1'b0;
    expect_eq("R9 load first", ptr, 13'h0777);
    start1_go = 1'b1; start2_go = 1'b1; tick();
    start1_go = 1'b0;
    expect_eq("R9 start1 over start2", ptr, 13'h0040);
    tick(); start2_go = 1'b0;
    expect_eq("R9 start2", ptr, 13'h1200);
  endtask

  task automatic t_mask();
    logic [DW-1:0] d;
    wr(3'd1, 16'h0000);
    wr(3'd0, 16'h001B);
    load(13'h04FF);
    steps(2);
    expect_eq("R10 keeps counting", ptr, 13'h0501);
    expect_eq("R10 output quiet", eob1_n, 1);
    rd(3'd1, d); expect_eq("R10 flag set", d, 16'h0001);
  endtask

  task automatic t_reserved();
    logic [DW-1:0] d;
    rd(3'd6, d); expect_eq("R12 sel6", d, 16'hFFFF);
    rd(3'd7, d); expect_eq("R12 sel7", d, 16'hFFFF);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_linear();
    t_chain();
    t_equal();
    t_stop();
    t_strobes();
    t_mask();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule